// File: doc/BRIEF.md
# Bus Slave Address Recognition Sequencer

This block is the address front end of a serial I/O function sitting on a shared parallel bus. It watches an active-low 16-bit address bus, an active-low write qualifier and an address strobe. When the strobe arrives with an address whose top digit is F and whose middle byte equals the block's own device number, it raises a master-select output, and with it the address-select and mux-select outputs that steer the rest of the function.

Once master-select is up, a timed handshake follows, with every step counted in clock cycles. The block waits a fixed delay. If the register code in the low address bits is valid, it then runs a reset window of the same length and after that a completion window. On a write, the reset window drives an active-low reset pulse to the neighbouring circuits. On a read that pulse is suppressed, and a data-out strobe is raised instead. The active-low completion pulse is handed to the bus access logic, which turns it into the bus done signal. A control-register code also raises a control-select output. When the strobe drops, the block returns to idle at once, even in the middle of a sequence.

Top module: `bus_addr_seq`

## Requirements
- R1: After reset, mst_sel, adr_sel, mux_sel, ctl_sel and dout_stb are low, and fn_rst_n and done_n are high.
- R2: With adr_stb high, the address is taken from the inverted bus (addr = ~addr_n). If addr[15:12] is 4'hF and addr[11:4] equals dev_id, mst_sel, adr_sel and mux_sel go high on the next clock edge. Any other address leaves all of them low.
- R3: The register code is addr[3:1]. Code 3'b000 selects the status register and 3'b001 selects the control register. Bit 0 is not decoded. For any other code, mst_sel still rises, but no reset pulse, completion pulse or data-out strobe follows.
- R4: On a write (wr_n low) with a valid code, fn_rst_n goes low for exactly DELAY_CYCLES cycles. It falls DELAY_CYCLES cycles after mst_sel rises.
- R5: For a valid code on either a read or a write, done_n goes low for exactly DELAY_CYCLES cycles. It falls in the cycle right after the reset window ends, which is 2*DELAY_CYCLES cycles after mst_sel rises. It never overlaps the reset pulse.
- R6: On a read (wr_n high) with a valid code, fn_rst_n stays high, and dout_stb is high in every cycle in which mst_sel is high.
- R7: ctl_sel is high together with mst_sel only when the code is 3'b001.
- R8: While adr_stb stays high after the sequence, mst_sel stays high and no second pulse is produced. Once adr_stb is low at a clock edge, all outputs are idle after that edge, which also cuts short any window in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_n | input | 16 | Active-low address bus |
| wr_n | input | 1 | Active-low write qualifier |
| adr_stb | input | 1 | Address strobe, active high |
| dev_id | input | 8 | This function's device number |
| mst_sel | output | 1 | Master select (first latch) |
| adr_sel | output | 1 | Address select, follows master select |
| mux_sel | output | 1 | Data mux select, follows master select |
| ctl_sel | output | 1 | Control register selected |
| dout_stb | output | 1 | Data-out strobe for reads |
| fn_rst_n | output | 1 | Active-low reset pulse to the function circuits |
| done_n | output | 1 | Active-low completion pulse |

## Verification
The bench measures where each pulse starts and how long it lasts, counted from the strobe. A counter that is off by one, or that reuses a stale count, would shift or stretch these windows. Near misses in the decode are tried one at a time: a wrong device byte, a wrong top digit, a cleared bit 15, and an invalid register code. A decoder that ignored a field would raise master-select, and one that did not lock out invalid codes would emit reset and done pulses. A strobe dropped in the middle of the reset window must clear everything with no done pulse afterwards. A strobe held long after the sequence must not restart it, or a second pulse would show up.

// File: rtl/bus_addr_seq_pkg.sv
package bus_addr_seq_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] CODE_STATUS = 3'b000;
    localparam logic [SEL_W-1:0] CODE_CTRL   = 3'b001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RST,
        PH_CMPL,
        PH_HOLD
    } phase_t;
endpackage

// File: rtl/addr_decode.sv
module addr_decode
    import bus_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [DEV_W-1:0]  dev_id,
    output logic              hit,
    output logic              valid,
    output logic              is_ctrl
);
    localparam int SEL_LSB = 1;
    localparam int DEV_LSB = SEL_LSB + SEL_W;
    localparam int TOP_LSB = DEV_LSB + DEV_W;

    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  code;
    logic              unused_byte_bit;

    always_comb begin
        addr    = ~addr_n;
        code    = addr[SEL_LSB +: SEL_W];
        hit     = (&addr[ADDR_W-1:TOP_LSB]) && (addr[DEV_LSB +: DEV_W] == dev_id);
        is_ctrl = (code == CODE_CTRL);
        valid   = (code == CODE_STATUS) || is_ctrl;
    end

    assign unused_byte_bit = addr[0];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import bus_addr_seq_pkg::*;
#(
    parameter int DELAY_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic wr_n,
    input  logic hit,
    input  logic valid,
    input  logic is_ctrl,
    output logic mst,
    output logic ctl,
    output logic dout,
    output logic fn_rst_n,
    output logic done_n
);
    localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    typedef struct packed {
        phase_t        phase;
        logic [CW-1:0] cnt;
        logic          wr;
        logic          valid;
        logic          ctl;
    } seq_t;

    localparam seq_t IDLE_S = '{phase: PH_IDLE, cnt: '0, wr: 1'b0, valid: 1'b0, ctl: 1'b0};

    seq_t s_d, s_q;
    logic at_last;

    always_comb begin
        s_d     = s_q;
        at_last = (s_q.cnt == LAST);
        if (!stb) begin
            s_d = IDLE_S;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (hit) begin
                        s_d.phase = PH_WAIT;
                        s_d.cnt   = '0;
                        s_d.wr    = !wr_n;
                        s_d.valid = valid;
                        s_d.ctl   = is_ctrl;
                    end
                end
                PH_WAIT: begin
                    if (at_last) begin
                        s_d.cnt   = '0;
                        s_d.phase = s_q.valid ? PH_RST : PH_HOLD;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_RST: begin
                    if (at_last) begin
                        s_d.cnt   = '0;
                        s_d.phase = PH_CMPL;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_CMPL: begin
                    if (at_last) begin
                        s_d.cnt   = '0;
                        s_d.phase = PH_HOLD;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_HOLD: s_d = s_q;
                default: s_d = IDLE_S;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= IDLE_S;
        else        s_q <= s_d;
    end

    always_comb begin
        mst      = (s_q.phase != PH_IDLE);
        ctl      = mst && s_q.ctl;
        dout     = mst && !s_q.wr && s_q.valid;
        fn_rst_n = !((s_q.phase == PH_RST) && s_q.wr);
        done_n   = (s_q.phase != PH_CMPL);
    end
endmodule

// File: rtl/bus_addr_seq.sv
module bus_addr_seq #(
    parameter int ADDR_W       = 16,
    parameter int DEV_W        = 8,
    parameter int DELAY_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic              wr_n,
    input  logic              adr_stb,
    input  logic [DEV_W-1:0]  dev_id,
    output logic              mst_sel,
    output logic              adr_sel,
    output logic              mux_sel,
    output logic              ctl_sel,
    output logic              dout_stb,
    output logic              fn_rst_n,
    output logic              done_n
);
    logic hit, valid, is_ctrl;

    addr_decode #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_dec (
        .addr_n (addr_n),
        .dev_id (dev_id),
        .hit    (hit),
        .valid  (valid),
        .is_ctrl(is_ctrl)
    );

    seq_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (adr_stb),
        .wr_n    (wr_n),
        .hit     (hit),
        .valid   (valid),
        .is_ctrl (is_ctrl),
        .mst     (mst_sel),
        .ctl     (ctl_sel),
        .dout    (dout_stb),
        .fn_rst_n(fn_rst_n),
        .done_n  (done_n)
    );

    assign adr_sel = mst_sel;
    assign mux_sel = mst_sel;
endmodule

// File: rtl/bus_addr_seq_chk.sv
module bus_addr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic adr_stb,
    input logic mst_sel,
    input logic ctl_sel,
    input logic dout_stb,
    input logic fn_rst_n,
    input logic done_n
);
    // R4
    rst_needs_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_rst_n |-> mst_sel);
    // R5
    done_needs_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_n |-> mst_sel);
    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_rst_n |-> done_n);
    // R5
    done_follows_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fn_rst_n) && mst_sel) |-> !done_n);
    // R6
    read_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_stb |-> fn_rst_n);
    // R7
    ctl_needs_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |-> mst_sel);
    // R8
    idle_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_stb |=> (!mst_sel && fn_rst_n && done_n && !dout_stb));
endmodule

bind bus_addr_seq bus_addr_seq_chk u_chk (.*);

// File: tb/bus_addr_seq_test.sv
module bus_addr_seq_test;
    localparam int D = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_n = 16'hFFFF;
    logic        wr_n = 1'b1;
    logic        adr_stb = 1'b0;
    logic [7:0]  dev_id = 8'h3C;
    logic mst_sel, adr_sel, mux_sel, ctl_sel, dout_stb, fn_rst_n, done_n;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_addr_seq #(.DELAY_CYCLES(D)) uut (
        .clk(clk), .rst_n(rst_n), .addr_n(addr_n), .wr_n(wr_n),
        .adr_stb(adr_stb), .dev_id(dev_id), .mst_sel(mst_sel),
        .adr_sel(adr_sel), .mux_sel(mux_sel), .ctl_sel(ctl_sel),
        .dout_stb(dout_stb), .fn_rst_n(fn_rst_n), .done_n(done_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, "mst_sel idle", int'(mst_sel), 0);
        chk(req, "adr/mux idle", int'(adr_sel | mux_sel), 0);
        chk(req, "ctl/dout idle", int'(ctl_sel | dout_stb), 0);
        chk(req, "fn_rst_n idle", int'(fn_rst_n), 1);
        chk(req, "done_n idle", int'(done_n), 1);
    endtask

    // Runs one strobe with logical address a, then drops it; compares pulse positions.
    task automatic run_access(input string req, input logic [15:0] a, input logic wr,
                              input bit e_mst, input bit e_rst, input bit e_done,
                              input bit e_dout, input bit e_ctl);
        int mst_n = 0, rst_first = 0, rst_n_cnt = 0, done_first = 0, done_cnt = 0;
        int dout_n = 0, ctl_n = 0, sel_bad = 0;
        @(negedge clk);
        addr_n  = ~a;
        wr_n    = ~wr;
        adr_stb = 1'b1;
        for (int i = 1; i <= 4 * D; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (mst_sel) mst_n++;
            if (adr_sel != mst_sel || mux_sel != mst_sel) sel_bad++;
            if (!fn_rst_n) begin
                if (rst_n_cnt == 0) rst_first = i;
                rst_n_cnt++;
            end
            if (!done_n) begin
                if (done_cnt == 0) done_first = i;
                done_cnt++;
            end
            if (dout_stb) dout_n++;
            if (ctl_sel) ctl_n++;
        end
        chk(req, "mst_sel cycles", mst_n, e_mst ? 4 * D : 0);
        chk(req, "adr/mux follow mst", sel_bad, 0);
        chk(req, "reset pulse start", rst_first, e_rst ? D + 1 : 0);
        chk(req, "reset pulse width", rst_n_cnt, e_rst ? D : 0);
        chk(req, "done pulse start", done_first, e_done ? 2 * D + 1 : 0);
        chk(req, "done pulse width", done_cnt, e_done ? D : 0);
        chk(req, "dout_stb cycles", dout_n, e_dout ? 4 * D : 0);
        chk(req, "ctl_sel cycles", ctl_n, e_ctl ? 4 * D : 0);
        adr_stb = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_idle("R8");
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic test_write_status();
        run_access("R4", 16'hF3C0, 1'b1, 1, 1, 1, 0, 0);
    endtask

    task automatic test_read_status();
        // R6, R3: bit 0 set is ignored
        run_access("R6", 16'hF3C1, 1'b0, 1, 0, 1, 1, 0);
    endtask

    task automatic test_wrong_dev();
        run_access("R2", 16'hF3D0, 1'b1, 0, 0, 0, 0, 0);
    endtask

    task automatic test_wrong_nibble();
        run_access("R2", 16'hE3C0, 1'b1, 0, 0, 0, 0, 0);
        run_access("R2", 16'h73C0, 1'b1, 0, 0, 0, 0, 0);
    endtask

    task automatic test_invalid_code();
        run_access("R3", 16'hF3CA, 1'b1, 1, 0, 0, 0, 0);
        run_access("R3", 16'hF3CE, 1'b0, 1, 0, 0, 0, 0);
    endtask

    task automatic test_control();
        run_access("R7", 16'hF3C2, 1'b1, 1, 1, 1, 0, 1);
        dev_id = 8'hA5;
        run_access("R5", 16'hFA53, 1'b0, 1, 0, 1, 1, 1);
        dev_id = 8'h3C;
    endtask

    task automatic test_abort();
        int done_seen = 0;
        @(negedge clk);
        addr_n  = ~16'hF3C0;
        wr_n    = 1'b0;
        adr_stb = 1'b1;
        for (int i = 1; i <= D + 2; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8", "in reset window before drop", int'(fn_rst_n), 0);
        adr_stb = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_idle("R8");
        for (int i = 0; i < 3 * D; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!done_n || mst_sel) done_seen++;
        end
        chk("R8", "activity after abort", done_seen, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write_status();
        test_read_status();
        test_wrong_dev();
        test_wrong_nibble();
        test_invalid_code();
        test_control();
        test_abort();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule